// File: doc/BRIEF.md
# Banked Interrupt Steering Bank

This block is one bank of a level-sensitive interrupt controller that serves 32 lines. Each line is pending when its external input is high or when software has forced it. Two independent enable masks gate the pending lines, one for the main CPU and one for a coprocessor. For each of the two targets, a per-line class bit then picks whether an enabled pending line raises the normal request or the fast request. The four request outputs are registered.

Software reaches the bank through a single-cycle register port. A write is taken on the rising edge where `bus_wr` is high. A read is combinational from `bus_addr`. The enable and force registers are never written directly. Software changes them through a set alias or a clear alias: a one bit in the written word acts on that line, and a zero bit leaves it alone. A system with more than 32 lines places several banks side by side. Global interrupt number k is served by bank k/32 on line k%32.

Top module: `irqb_bank`

## Requirements
- R1: After a synchronous active-low reset, every enable, force and class register reads 0 and all four request outputs are 0.
- R2: The CPU enable mask reads at offset 0x20. A write to 0x24 sets the enable bits where the data has ones. A write to 0x28 clears them. Zero data bits leave the enables unchanged, and writing all ones to 0x28 disables every line.
- R3: The coprocessor enable mask reads at 0x30 and has a set alias at 0x34 and a clear alias at 0x38. These aliases work the same way as the CPU aliases.
- R4: The force register reads at 0x14. A write to 0x18 sets force bits where the data has ones. A write to 0x1C clears them, and this is how a forced line is acknowledged.
- R5: The CPU class register at 0x2C and the coprocessor class register at 0x3C are loaded with the whole written word and read back that value. Class bit n = 0 sends line n to the normal request, and 1 sends it to the fast request. Writing 0 sends every line to the normal request.
- R6: Line n is pending when `irq_in[n]` is high or force bit n is set. `cpu_irq` is the OR over lines that are pending, CPU-enabled and have CPU class 0. `cpu_fiq` is the same for CPU class 1. `cop_irq` and `cop_fiq` follow the same rule with the coprocessor enable and class registers.
- R7: A read at 0x08 returns the vector of lines that are pending, CPU-enabled and have CPU class 1.
- R8: A read at any offset outside {0x08, 0x14, 0x18, 0x1C, 0x20, 0x24, 0x28, 0x2C, 0x30, 0x34, 0x38, 0x3C} returns 0. A write to an unmapped offset changes no state. A write to one of the read-only offsets 0x08, 0x14, 0x20 or 0x30 also changes no state.
- R9: A read at a set or clear alias offset returns the value of the register that the alias modifies.
- R10: A register write changes the request outputs one clock after the edge that takes the write. A change on `irq_in` reaches the outputs on the next rising edge.
- R11: Writes that target one of the CPU or coprocessor registers leave the other target's enable and class registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | LINES | External level interrupt lines |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Combinational read data for `bus_addr` |
| cpu_irq | output | 1 | CPU normal request |
| cpu_fiq | output | 1 | CPU fast request |
| cop_irq | output | 1 | Coprocessor normal request |
| cop_fiq | output | 1 | Coprocessor fast request |

## Verification
The gating is tried with a forced line alone, with an external line alone, and with a line that is both external and forced. These patterns show whether the pending term is a true OR of the two sources. Each pattern is then run with class 0 and with class 1, on the CPU side and on the coprocessor side. That separates the normal and fast paths and shows that the two targets do not share masks. Set and clear writes with mixed one and zero bits show whether zero bits are really ignored. Samples taken just before and just after the expected edge expose an output that is one clock early or one clock late.

// File: rtl/irqb_pkg.sv
// Shared register offsets of the interrupt steering bank.
// Assumes byte offsets with 32-bit aligned registers.
package irqb_pkg;
    localparam int OFS_FIQ_VIEW  = 'h08;
    localparam int OFS_FRC       = 'h14;
    localparam int OFS_FRC_SET   = 'h18;
    localparam int OFS_FRC_CLR   = 'h1C;
    localparam int OFS_TGT_BASE  = 'h20;
    localparam int TGT_STRIDE    = 'h10;
    localparam int REL_EN        = 'h0;
    localparam int REL_SET       = 'h4;
    localparam int REL_CLR       = 'h8;
    localparam int REL_CLS       = 'hC;
    localparam int NUM_TGT       = 2;   // 0: CPU, 1: coprocessor

    // Offset of register 'rel' of target 't'.
    function automatic int tgt_ofs(input int t, input int rel);
        return OFS_TGT_BASE + TGT_STRIDE * t + rel;
    endfunction
endpackage

// File: rtl/irqb_mask_reg.sv
// Mask register with whole-word load and write-one-to-set / clear aliases.
// Assumes at most one strobe is high per cycle (the decoder ensures this).
module irqb_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_stb,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Update the mask from whichever access strobe is active.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load_stb) q <= wdata;
        else if (set_stb)  q <= q | wdata;
        else if (clr_stb)  q <= q & ~wdata;
    end
endmodule

// File: rtl/irqb_target_route.sv
// Gates pending lines with one target's enable mask and splits them into
// registered normal / fast requests by class bit. Assumes level inputs.
module irqb_target_route #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pending,
    input  logic [W-1:0] enable,
    input  logic [W-1:0] cls,
    output logic         irq_o,
    output logic         fiq_o
);
    logic [W-1:0] live;

    // Lines that are both pending and enabled for this target.
    always_comb live = pending & enable;

    // Register the OR-reduced requests of each class.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(live & ~cls);
            fiq_o <= |(live & cls);
        end
    end
endmodule

// File: rtl/irqb_bank.sv
// One bank of the interrupt steering controller: force register, per-target
// enable and class registers, register decode and request outputs.
// Assumes a single-cycle bus: writes taken at the rising edge, reads combinational.
module irqb_bank
    import irqb_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    output logic              cpu_irq,
    output logic              cpu_fiq,
    output logic              cop_irq,
    output logic              cop_fiq
);
    logic [LINES-1:0]              frc_q;
    logic [LINES-1:0]              pending;
    logic [LINES-1:0]              fiq_view;
    logic [NUM_TGT-1:0][LINES-1:0] en_q;
    logic [NUM_TGT-1:0][LINES-1:0] cls_q;
    logic [NUM_TGT-1:0]            irq_o;
    logic [NUM_TGT-1:0]            fiq_o;

    // Force register strobes from the two alias offsets.
    logic frc_set_stb, frc_clr_stb;
    always_comb begin
        frc_set_stb = bus_wr && (bus_addr == ADDR_W'(OFS_FRC_SET));
        frc_clr_stb = bus_wr && (bus_addr == ADDR_W'(OFS_FRC_CLR));
    end

    irqb_mask_reg #(.W(LINES)) u_frc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_stb (1'b0),
        .set_stb  (frc_set_stb),
        .clr_stb  (frc_clr_stb),
        .wdata    (bus_wdata),
        .q        (frc_q)
    );

    // Pending lines combine the external levels and the forced bits.
    always_comb pending = irq_in | frc_q;

    // Fast-classified live lines of the CPU target, for the read-only view.
    always_comb fiq_view = pending & en_q[0] & cls_q[0];

    // One enable mask, class register and router per target.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        logic en_set_stb, en_clr_stb, cls_load_stb;

        // Decode this target's alias and class offsets.
        always_comb begin
            en_set_stb   = bus_wr && (bus_addr == ADDR_W'(tgt_ofs(t, REL_SET)));
            en_clr_stb   = bus_wr && (bus_addr == ADDR_W'(tgt_ofs(t, REL_CLR)));
            cls_load_stb = bus_wr && (bus_addr == ADDR_W'(tgt_ofs(t, REL_CLS)));
        end

        irqb_mask_reg #(.W(LINES)) u_en (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_stb (1'b0),
            .set_stb  (en_set_stb),
            .clr_stb  (en_clr_stb),
            .wdata    (bus_wdata),
            .q        (en_q[t])
        );

        irqb_mask_reg #(.W(LINES)) u_cls (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_stb (cls_load_stb),
            .set_stb  (1'b0),
            .clr_stb  (1'b0),
            .wdata    (bus_wdata),
            .q        (cls_q[t])
        );

        irqb_target_route #(.W(LINES)) u_route (
            .clk     (clk),
            .rst_n   (rst_n),
            .pending (pending),
            .enable  (en_q[t]),
            .cls     (cls_q[t]),
            .irq_o   (irq_o[t]),
            .fiq_o   (fiq_o[t])
        );
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_FIQ_VIEW))
            bus_rdata = fiq_view;
        if (bus_addr == ADDR_W'(OFS_FRC) || bus_addr == ADDR_W'(OFS_FRC_SET) ||
            bus_addr == ADDR_W'(OFS_FRC_CLR))
            bus_rdata = frc_q;
        for (int t = 0; t < NUM_TGT; t++) begin
            if (bus_addr == ADDR_W'(tgt_ofs(t, REL_EN))  ||
                bus_addr == ADDR_W'(tgt_ofs(t, REL_SET)) ||
                bus_addr == ADDR_W'(tgt_ofs(t, REL_CLR)))
                bus_rdata = en_q[t];
            if (bus_addr == ADDR_W'(tgt_ofs(t, REL_CLS)))
                bus_rdata = cls_q[t];
        end
    end

    // Map the target-indexed requests onto named ports.
    always_comb begin
        cpu_irq = irq_o[0];
        cpu_fiq = fiq_o[0];
        cop_irq = irq_o[1];
        cop_fiq = fiq_o[1];
    end
endmodule

// File: rtl/irqb_bank_chk.sv
// Property checker for irqb_bank, bound into every instance.
// Assumes reset is held for at least two clock edges.
module irqb_bank_chk
    import irqb_pkg::*;
#(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [LINES-1:0]              irq_in,
    input logic                          bus_wr,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [LINES-1:0]              bus_wdata,
    input logic [LINES-1:0]              bus_rdata,
    input logic                          cpu_irq,
    input logic                          cpu_fiq,
    input logic                          cop_irq,
    input logic                          cop_fiq,
    input logic [LINES-1:0]              frc_q,
    input logic [NUM_TGT-1:0][LINES-1:0] en_q,
    input logic [NUM_TGT-1:0][LINES-1:0] cls_q
);
    function automatic logic mapped(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        return (v == OFS_FIQ_VIEW) || (v >= OFS_FRC && v <= 'h3C && v[1:0] == 2'b00);
    endfunction

    function automatic logic is_cpu_ofs(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        return v >= OFS_TGT_BASE && v < OFS_TGT_BASE + TGT_STRIDE;
    endfunction

    // R2: set alias turns on every written one
    a_r2_cpu_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(tgt_ofs(0, REL_SET)))
        |=> ((en_q[0] & $past(bus_wdata)) == $past(bus_wdata)));
    // R2: clear alias turns off every written one
    a_r2_cpu_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(tgt_ofs(0, REL_CLR)))
        |=> ((en_q[0] & $past(bus_wdata)) == '0));
    // R3: coprocessor set alias
    a_r3_cop_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(tgt_ofs(1, REL_SET)))
        |=> ((en_q[1] & $past(bus_wdata)) == $past(bus_wdata)));
    // R4: force clear acknowledges the written lines
    a_r4_frc_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_FRC_CLR))
        |=> ((frc_q & $past(bus_wdata)) == '0));
    // R5: class register takes the whole word
    a_r5_cls_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(tgt_ofs(0, REL_CLS)))
        |=> (cls_q[0] == $past(bus_wdata)));
    // R6, R10: requests follow the gated state one edge later
    a_r6_cpu_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(|((irq_in | frc_q) & en_q[0] & ~cls_q[0])));
    a_r6_cpu_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fiq == $past(|((irq_in | frc_q) & en_q[0] & cls_q[0])));
    a_r6_cop_irq: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq == $past(|((irq_in | frc_q) & en_q[1] & ~cls_q[1])));
    a_r6_cop_fiq: assert property (@(posedge clk) disable iff (!rst_n)
        cop_fiq == $past(|((irq_in | frc_q) & en_q[1] & cls_q[1])));
    // R8: unmapped reads return zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped(bus_addr) |-> (bus_rdata == '0));
    // R11: CPU-side writes never touch coprocessor state
    a_r11_cop_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_cpu_ofs(bus_addr)) |=> ($stable(en_q[1]) && $stable(cls_q[1])));
endmodule

bind irqb_bank irqb_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irqb_bank_bench.sv
// Directed bench for irqb_bank: one task per scenario, each checking itself.
module irqb_bank_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LINES-1:0]  irq_in = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [LINES-1:0]  bus_wdata = '0;
    logic [LINES-1:0]  bus_rdata;
    logic              cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqb_bank #(.LINES(LINES), .ADDR_W(ADDR_W)) u_irqb_bank (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_irq(cpu_irq), .cpu_fiq(cpu_fiq), .cop_irq(cop_irq), .cop_fiq(cop_fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Outputs packed as {cpu_irq, cpu_fiq, cop_irq, cop_fiq}.
    function automatic logic [31:0] outs();
        return {28'd0, cpu_irq, cpu_fiq, cop_irq, cop_fiq};
    endfunction

    // Write taken at the next rising edge; returns on the following falling edge.
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = ADDR_W'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic t_reset();
        rdchk("R1 cpu enable", 'h20, 0);
        rdchk("R1 cop enable", 'h30, 0);
        rdchk("R1 force", 'h14, 0);
        rdchk("R1 cpu class", 'h2C, 0);
        rdchk("R1 cop class", 'h3C, 0);
        chk("R1 outputs", outs(), 0);
    endtask

    task automatic t_cpu_enable();
        wr('h24, 32'hA5A5_0000);
        rdchk("R2 set", 'h20, 32'hA5A5_0000);
        wr('h24, 32'h0000_00FF);
        rdchk("R2 set keeps zeros", 'h20, 32'hA5A5_00FF);
        wr('h28, 32'h0500_000F);
        rdchk("R2 clear", 'h20, 32'hA0A5_00F0);
        rdchk("R9 set alias read", 'h24, 32'hA0A5_00F0);
        rdchk("R9 clear alias read", 'h28, 32'hA0A5_00F0);
        rdchk("R11 cop untouched", 'h30, 0);
        wr('h28, 32'hFFFF_FFFF);
        rdchk("R2 clear all", 'h20, 0);
    endtask

    task automatic t_cop_enable();
        wr('h34, 32'h0000_F00F);
        rdchk("R3 set", 'h30, 32'h0000_F00F);
        rdchk("R11 cpu untouched", 'h20, 0);
        wr('h38, 32'h0000_0003);
        rdchk("R3 clear", 'h30, 32'h0000_F00C);
        rdchk("R9 cop clear alias read", 'h38, 32'h0000_F00C);
        wr('h38, 32'hFFFF_FFFF);
        rdchk("R3 clear all", 'h30, 0);
    endtask

    task automatic t_force();
        wr('h18, 32'h8000_0001);
        rdchk("R4 set", 'h14, 32'h8000_0001);
        rdchk("R9 force clear alias read", 'h1C, 32'h8000_0001);
        wr('h1C, 32'h0000_0001);
        rdchk("R4 clear", 'h14, 32'h8000_0000);
        wr('h1C, 32'hFFFF_FFFF);
        rdchk("R4 clear all", 'h14, 0);
    endtask

    task automatic t_routing();
        wr('h24, 32'h8);
        wr('h2C, 32'h0);
        wr('h18, 32'h8);
        chk("R10 not yet", outs(), 4'b0000);
        @(negedge clk);
        chk("R6 cpu irq forced", outs(), 4'b1000);
        wr('h2C, 32'h8);
        rdchk("R5 class readback", 'h2C, 32'h8);
        @(negedge clk);
        chk("R5 cpu fast", outs(), 4'b0100);
        rdchk("R7 fast view", 'h08, 32'h8);
        wr('h1C, 32'h8);
        @(negedge clk);
        chk("R4 ack drops", outs(), 4'b0000);
        rdchk("R7 view empty", 'h08, 0);
        irq_in = 32'h400;
        @(negedge clk);
        chk("R6 not enabled", outs(), 4'b0000);
        wr('h34, 32'h400);
        wr('h3C, 32'h0);
        @(negedge clk);
        chk("R6 cop irq external", outs(), 4'b0010);
        wr('h3C, 32'h400);
        @(negedge clk);
        chk("R11 cop fast only", outs(), 4'b0001);
        irq_in = '0;
        #1;
        chk("R10 line hold", outs(), 4'b0001);
        @(negedge clk);
        chk("R10 line drop", outs(), 4'b0000);
        wr('h18, 32'h400);
        irq_in = 32'h400;
        @(negedge clk);
        chk("R6 both sources", outs(), 4'b0001);
        irq_in = '0;
        @(negedge clk);
        chk("R6 force alone", outs(), 4'b0001);
        wr('h1C, 32'hFFFF_FFFF);
        wr('h38, 32'hFFFF_FFFF);
        wr('h28, 32'hFFFF_FFFF);
        wr('h2C, 32'h0);
        wr('h3C, 32'h0);
        rdchk("R5 zero class", 'h3C, 0);
    endtask

    task automatic t_unmapped();
        wr('h40, 32'hFFFF_FFFF);
        wr('h00, 32'hFFFF_FFFF);
        wr('h20, 32'hFFFF_FFFF);
        wr('h30, 32'hFFFF_FFFF);
        wr('h14, 32'hFFFF_FFFF);
        wr('h08, 32'hFFFF_FFFF);
        rdchk("R8 cpu enable kept", 'h20, 0);
        rdchk("R8 cop enable kept", 'h30, 0);
        rdchk("R8 force kept", 'h14, 0);
        rdchk("R8 read 0x40", 'h40, 0);
        rdchk("R8 read 0x0C", 'h0C, 0);
        rdchk("R8 read unaligned", 'h22, 0);
        irq_in = '1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 outputs quiet", outs(), 0);
        irq_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cpu_enable();
        t_cop_enable();
        t_force();
        t_routing();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule